// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block watches a stream of 16-bit sample words, each marked by a valid strobe, and records a window of them into an internal memory. A word counts as a trigger when its upper byte is at or above a fixed level. The block lets a set number of trigger events go by, accepts the next one, and then drops a set number of further valid words. After that it stores a fixed number of consecutive valid words.

A run begins with a start pulse. The controller first zeroes the whole capture memory, one address per cycle, and then starts watching for triggers. Both skip counts are taken from the configuration inputs at the moment the start pulse is accepted. When the memory is full, the controller raises `done` and holds it. The stored words can then be read through a simple registered read port. While a run is in progress, the read port returns zero.

Suggested settings are a trigger skip of 1 and a word skip of 10000. The capture depth is a parameter.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After synchronous reset the controller is idle: `busy`=0, `done`=0 and `rd_data`=0.
- R2: A start pulse is accepted only when `busy`=0, which covers both the idle and the done condition. When it is accepted, `busy` is 1 and `done` is 0 from the next cycle, and `cfg_trig_skip` and `cfg_word_skip` are latched. A start pulse while `busy`=1 has no effect on the run.
- R3: After an accepted start, the controller spends exactly DEPTH cycles writing zero to every memory address. Words presented during those cycles are ignored, including words at trigger level.
- R4: A trigger event is a cycle with `smp_valid`=1 and `smp_word[15:8]` >= 240. A word with upper byte 239 is not a trigger, and trigger-level data with `smp_valid`=0 is not a trigger. Each valid strobe counts at most one event.
- R5: The first `cfg_trig_skip` trigger events after the clear phase are ignored. The next event is accepted. The accepted trigger word itself is not stored.
- R6: After the accepted trigger, the next `cfg_word_skip` valid words are discarded. Cycles with `smp_valid`=0 are not counted. A skip count of 0 makes storing begin with the next valid word.
- R7: The next DEPTH valid words after the skip are written to addresses 0, 1, … DEPTH-1 in arrival order, with no gaps.
- R8: `busy` falls and `done` rises in the cycle after the edge that stores the last word. `done` then stays 1 until an accepted start. Words arriving while the controller is idle or done change nothing.
- R9: `rd_data` is registered. One cycle after `rd_addr` is presented, it shows that word of memory when `busy`=0, and it shows 0 when `busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request pulse |
| cfg_trig_skip | input | TSKIP_W | Trigger events to let pass |
| cfg_word_skip | input | WSKIP_W | Valid words to drop after the accepted trigger |
| smp_valid | input | 1 | Sample strobe |
| smp_word | input | SMP_W | Sample word; upper byte is compared against the trigger level |
| busy | output | 1 | Run in progress (clearing, armed, skipping or storing) |
| done | output | 1 | Capture complete, held until next accepted start |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | SMP_W | Registered read data, zero while busy |

## Verification
The first directed stream sits just below the trigger level at upper byte 239. It also holds a trigger-level word with the strobe low, and then a word at exactly 240. Both skip counts are zero. This separates the `>=` comparison from `>` and shows whether the strobe gates trigger detection. During every clear window the bench drives trigger-level words with the strobe high, which shows whether the clear phase really ignores input. The random runs mix gaps in the strobe, sparse triggers and varied skip counts, and one of them carries a start pulse in the middle of the run. A reference model built from the requirements predicts, for each run, the stored window and the exact cycle in which `done` rises. Mismatches there separate off-by-one errors in trigger counting, in word skipping and in the store address.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CLEAR   = 3'd1,
        ST_ARM     = 3'd2,
        ST_SKIP    = 3'd3,
        ST_CAPTURE = 3'd4,
        ST_DONE    = 3'd5
    } tcap_state_e;

    function automatic logic level_reached(input logic [BYTE_W-1:0] hi, input int level);
        return hi >= BYTE_W'(level);
    endfunction

endpackage

// File: rtl/tcap_trigger.sv
module tcap_trigger
    import tcap_pkg::*;
#(
    parameter int LEVEL = 240
) (
    input  logic              valid,
    input  logic [BYTE_W-1:0] hi_byte,
    output logic              hit
);
    // one event per strobe; no strobe, no event
    assign hit = valid && level_reached(hi_byte, LEVEL);
endmodule

// File: rtl/tcap_seq.sv
module tcap_seq
    import tcap_pkg::*;
#(
    parameter int SMP_W   = 16,
    parameter int DEPTH   = 64,
    parameter int TSKIP_W = 8,
    parameter int WSKIP_W = 16,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TSKIP_W-1:0] cfg_trig_skip,
    input  logic [WSKIP_W-1:0] cfg_word_skip,
    input  logic               smp_valid,
    input  logic [SMP_W-1:0]   smp_word,
    input  logic               trig_hit,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [SMP_W-1:0]   wr_data,
    output logic               busy,
    output logic               done
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    tcap_state_e        state;
    logic [ADDR_W-1:0]  ptr;
    logic [TSKIP_W-1:0] tskip_q, tcnt;
    logic [WSKIP_W-1:0] wskip_q, wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ptr     <= '0;
            tskip_q <= '0;
            wskip_q <= '0;
            tcnt    <= '0;
            wcnt    <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state   <= ST_CLEAR;
                        ptr     <= '0;
                        tskip_q <= cfg_trig_skip;
                        wskip_q <= cfg_word_skip;
                        tcnt    <= '0;
                        wcnt    <= '0;
                    end
                end
                ST_CLEAR: begin
                    if (ptr == LAST_ADDR) begin
                        ptr   <= '0;
                        state <= ST_ARM;
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_ARM: begin
                    if (trig_hit) begin
                        if (tcnt == tskip_q)
                            state <= (wskip_q == '0) ? ST_CAPTURE : ST_SKIP;
                        else
                            tcnt <= tcnt + 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (smp_valid) begin
                        if (wcnt == wskip_q - WSKIP_W'(1))
                            state <= ST_CAPTURE;
                        else
                            wcnt <= wcnt + 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    if (smp_valid) begin
                        if (ptr == LAST_ADDR) begin
                            ptr   <= '0;
                            state <= ST_DONE;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wr_en   = (state == ST_CLEAR) || (state == ST_CAPTURE && smp_valid);
    assign wr_addr = ptr;
    assign wr_data = (state == ST_CLEAR) ? '0 : smp_word;
    assign busy    = (state == ST_CLEAR) || (state == ST_ARM) ||
                     (state == ST_SKIP)  || (state == ST_CAPTURE);
    assign done    = (state == ST_DONE);

    AST_CLEAR_EXIT: assert property (@(posedge clk) disable iff (rst) (state == ST_CLEAR) |=> (state == ST_CLEAR || state == ST_ARM)); // R3
    AST_ARM_WAITS: assert property (@(posedge clk) disable iff (rst) (state == ST_ARM && !trig_hit) |=> (state == ST_ARM)); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) ((state == ST_ARM || state == ST_SKIP || state == ST_CAPTURE) && start) |=> (state != ST_CLEAR)); // R2
    AST_CAP_NO_GAP: assert property (@(posedge clk) disable iff (rst) (state == ST_CAPTURE && !smp_valid) |=> $stable(ptr)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst) (state == ST_DONE && !start) |=> (state == ST_DONE)); // R8
    AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> ($past(state) == ST_CAPTURE && $past(smp_valid))); // R8
endmodule

// File: rtl/tcap_mem.sv
module tcap_mem #(
    parameter int SMP_W = 16,
    parameter int DEPTH = 64,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SMP_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SMP_W-1:0]  rd_data
);
    logic [SMP_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || busy)
            rd_data <= '0;
        else
            rd_data <= store[rd_addr];
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst) wr_en |-> (int'(wr_addr) < DEPTH)); // R7
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import tcap_pkg::*;
#(
    parameter int SMP_W      = 16,
    parameter int DEPTH      = 64,
    parameter int TRIG_LEVEL = 240,
    parameter int TSKIP_W    = 8,
    parameter int WSKIP_W    = 16,
    localparam int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TSKIP_W-1:0] cfg_trig_skip,
    input  logic [WSKIP_W-1:0] cfg_word_skip,
    input  logic               smp_valid,
    input  logic [SMP_W-1:0]   smp_word,
    output logic               busy,
    output logic               done,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [SMP_W-1:0]   rd_data
);
    logic              trig_hit;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [SMP_W-1:0]  wr_data;

    tcap_trigger #(.LEVEL(TRIG_LEVEL)) u_trig (
        .valid   (smp_valid),
        .hi_byte (smp_word[SMP_W-1 -: BYTE_W]),
        .hit     (trig_hit)
    );

    tcap_seq #(
        .SMP_W(SMP_W), .DEPTH(DEPTH), .TSKIP_W(TSKIP_W), .WSKIP_W(WSKIP_W)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_trig_skip(cfg_trig_skip), .cfg_word_skip(cfg_word_skip),
        .smp_valid(smp_valid), .smp_word(smp_word), .trig_hit(trig_hit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    tcap_mem #(.SMP_W(SMP_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    AST_READ_BLANK: assert property (@(posedge clk) disable iff (rst) busy |=> (rd_data == '0)); // R9
endmodule

// File: tb/tb_trig_capture_ctrl.sv
module tb_trig_capture_ctrl;
    localparam int DEPTH = 64;
    localparam int SLEN  = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  cfg_trig_skip = '0;
    logic [15:0] cfg_word_skip = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_word = '0;
    logic        busy, done;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic        sv [SLEN];
    logic [15:0] sw [SLEN];
    logic [15:0] exp_mem [DEPTH];
    int          fin;

    always #5 clk = ~clk;

    trig_capture_ctrl dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_trig_skip(cfg_trig_skip), .cfg_word_skip(cfg_word_skip),
        .smp_valid(smp_valid), .smp_word(smp_word),
        .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // reference model from R4..R7
    task automatic model(input int n, input int m, input int len);
        int phase = 0, tc = 0, sc = 0, wi = 0;
        fin = -1;
        for (int i = 0; i < len; i++) begin
            if (fin >= 0) break;
            if (!sv[i]) continue;
            case (phase)
                0: if (sw[i][15:8] >= 8'd240) begin
                       if (tc == n) phase = (m == 0) ? 2 : 1;
                       else tc++;
                   end
                1: begin sc++; if (sc == m) phase = 2; end
                default: begin
                    exp_mem[wi] = sw[i];
                    wi++;
                    if (wi == DEPTH) fin = i;
                end
            endcase
        end
    endtask

    task automatic gen_stream(input int len);
        for (int i = 0; i < len; i++) begin
            sv[i] = ($urandom % 100) < 75;
            if (($urandom % 100) < 8)
                sw[i] = {8'(240 + $urandom % 16), 8'($urandom)};
            else
                sw[i] = {8'($urandom % 240), 8'($urandom)};
        end
    endtask

    task automatic run(input int n, input int m, input int len, input bit midstart);
        int tmis = 0;
        model(n, m, len);
        if (fin < 0) begin
            chk(0, "R7 stream too short", fin, 0);
            return;
        end
        @(negedge clk);
        start = 1'b1; cfg_trig_skip = 8'(n); cfg_word_skip = 16'(m);
        @(negedge clk);
        start = 1'b0; cfg_trig_skip = '0; cfg_word_skip = '0;
        chk(busy == 1'b1 && done == 1'b0, "R2 busy after start", {busy, done}, 2);
        // clear window: trigger-level words that must be ignored (R3)
        for (int k = 0; k < DEPTH; k++) begin
            smp_valid = 1'b1; smp_word = 16'hF8A0 + 16'(k);
            if (k > 0) @(negedge clk);
            if (k == DEPTH - 1) ;
        end
        for (int i = 0; i <= len; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (done !== (i - 1 >= fin) || busy !== (i - 1 < fin)) tmis++;
            end
            if (i == 12 && busy) chk(rd_data == 16'h0, "R9 read blank while busy", int'(rd_data), 0);
            if (i < len) begin
                smp_valid = sv[i]; smp_word = sw[i];
                start = midstart && (i == 5);
                rd_addr = (i == 10) ? 6'd3 : rd_addr;
            end else begin
                smp_valid = 1'b0; start = 1'b0;
            end
        end
        chk(tmis == 0, "R8 busy/done timing", tmis, 0);
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R8 done held", int'(done), 1);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = 6'(a);
            @(negedge clk);
            chk(rd_data == exp_mem[a], $sformatf("R7 R5 R6 R3 word %0d", a), int'(rd_data), int'(exp_mem[a]));
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0 && done == 1'b0 && rd_data == 16'h0, "R1 reset state", {busy, done}, 0);

        // directed: R4 boundary, zero skips
        for (int i = 0; i < 200; i++) begin sv[i] = 1'b1; sw[i] = 16'h0123; end
        for (int i = 0; i < 10; i++) sw[i] = {8'd239, 8'(i)};
        sv[10] = 1'b0; sw[10] = 16'hFFFF;
        sw[11] = 16'hF000;
        for (int k = 0; k < DEPTH; k++) sw[12 + k] = 16'h1000 + 16'(k);
        for (int i = 12 + DEPTH; i < 200; i++) sw[i] = 16'hFEED;
        run(0, 0, 200, 1'b0);
        chk(exp_mem[0] == 16'h1000 && fin == 11 + DEPTH, "R4 boundary model", fin, 11 + DEPTH);

        // directed: start accepted from DONE clears done (R2)
        gen_stream(900);
        @(negedge clk);
        run(1, 10, 900, 1'b1);

        for (int r = 0; r < 3; r++) begin
            gen_stream(900);
            run(int'($urandom % 4), int'($urandom % 41), 900, r[0]);
        end

        // words in DONE ignored: memory unchanged after more traffic (R8)
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); smp_valid = 1'b1; smp_word = 16'hF1F1;
        end
        @(negedge clk); smp_valid = 1'b0; rd_addr = 6'd0;
        @(negedge clk);
        chk(rd_data == exp_mem[0] && done, "R8 idle words ignored", int'(rd_data), int'(exp_mem[0]));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule